// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Controller

This block holds the interrupt and halt logic for a single DMA channel. It keeps the channel's transfer counter and repeat-run counter. For every incoming transfer request it decides whether the transfer may go ahead. It does this by comparing the remaining byte count with the size of one request, and that size depends on the transfer mode. The address generators report area-overflow events as strobes. The block turns these events and counter exhaustion into two sticky flags. The end flag is for counter exhaustion and the special flag covers every other cause. The two flags are ORed onto one interrupt line.

Software uses four registers. The control register holds the channel enable, the two flags and five per-source enables. The other three are the transfer counter, the repeat size, and a read-only view of the repeat-run counter. Whenever a flag is raised the channel enable drops, so the channel stays stopped until software re-arms it.

Top module: `dma_chan_irq`

## Requirements
- R1: After reset, the channel enable, both flags, all five source enables, the transfer counter, the repeat size and the run counter read 0, and `irq_o` is low.
- R2: A request is performed (`xfer_go_o`=1 in the same cycle) only if the channel is enabled, there is no size error, and no repeat stop applies. A performed request lowers the transfer counter by one request size at the next edge.
- R3: One request size depends on `xfer_mode_i`. In normal (0) and repeat (3) mode it is 1<<`acc_size_i` bytes. In block mode (1) it is `blk_size_i`, and in cluster mode (2) it is `clu_size_i`. An enabled request while the counter is below that size is a size error. In that case `sz_err_o` is 1 in that cycle, the request is not performed, the counter keeps its value, the channel enable clears, and the special flag sets if the size-error enable is 1.
- R4: If a performed request brings the counter to 0 and the end enable is 1, the end flag sets. This does not happen when a special cause occurs in the same cycle.
- R5: When its enable is 1, a source overflow strobe (`src_ovf_i`) or a destination overflow strobe (`dst_ovf_i`) sets the special flag.
- R6: If an enabled special cause coincides with counter exhaustion, only the special flag sets.
- R7: In repeat mode, the run counter loads the repeat size and drops by 1 on each performed request. A request that arrives while the counter is 0 is a repeat stop. If the repeat enable is 1, the request is not performed, the special flag sets and the run counter reloads to the repeat size. If the repeat enable is 0, the request is performed and the run counter becomes the repeat size minus 1.
- R8: In any cycle in which a flag sets or a size error occurs, the channel enable clears. This takes priority over a software write.
- R9: Register map, selected by `reg_addr_i`. Address 0 is control, address 1 is the transfer counter, address 2 is the repeat size (a write also loads the run counter), and address 3 is the run counter (read-only). The control bits are: [0] enable, [1] end flag, [2] special flag, [3] end enable, [4] size-error enable, [5] repeat enable, [6] source-overflow enable, [7] destination-overflow enable. Writing 0 to a flag clears it and writing 1 to a flag leaves it unchanged. Writing 1 to the enable bit also clears the end flag. A flag set by hardware takes priority over the clear. A write to the counter or repeat size takes priority over the decrement in that cycle.
- R10: `irq_o` is 1 exactly when at least one flag is set.
- R11: A cause whose enable is 0 sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register (combinational) |
| req_i | input | 1 | Transfer request |
| xfer_mode_i | input | 2 | 0 normal, 1 block, 2 cluster, 3 repeat |
| acc_size_i | input | 2 | Access size, log2 of bytes |
| blk_size_i | input | 16 | Block size in bytes |
| clu_size_i | input | 16 | Cluster size in bytes |
| src_ovf_i | input | 1 | Source extended-area overflow strobe |
| dst_ovf_i | input | 1 | Destination extended-area overflow strobe |
| xfer_go_o | output | 1 | Request performed this cycle |
| sz_err_o | output | 1 | Size error this cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
`xfer_go_o` and `sz_err_o` depend combinationally on the current request and the registered state, so they are due in the same cycle as the request. Counter, run-counter, flag, enable and `irq_o` changes appear one edge after the request, strobe or write that causes them. The bench drives inputs 1 ns after the rising edge and compares at the falling edge. In that way a same-cycle result is seen while its request is still held, and a registered result is seen in the cycle that follows. The behavioural model updates its state only after its comparison, so each expected value is tied to the right cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_BLK  = 2'd1,
    MODE_CLU  = 2'd2,
    MODE_RPT  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_TCNT = 2'd1,
    RA_RSZ  = 2'd2,
    RA_RUN  = 2'd3
  } reg_addr_e;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_ENDF = 1;
  localparam int unsigned CB_SPF  = 2;
  localparam int unsigned CB_IE   = 3;
  localparam int unsigned N_IE    = 5;
  localparam int unsigned CTRL_W  = CB_IE + N_IE;

  // enable vector index
  localparam int unsigned IE_END = 0;
  localparam int unsigned IE_SZ  = 1;
  localparam int unsigned IE_RPT = 2;
  localparam int unsigned IE_SRC = 3;
  localparam int unsigned IE_DST = 4;
endpackage

// File: rtl/dma_req_size.sv
module dma_req_size
  import dma_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [1:0]       mode_i,
  input  logic [1:0]       acc_size_i,
  input  logic [CNT_W-1:0] blk_size_i,
  input  logic [CNT_W-1:0] clu_size_i,
  input  logic [CNT_W-1:0] tcnt_i,
  input  logic             req_i,
  input  logic             chan_en_i,
  output logic [CNT_W-1:0] unit_o,
  output logic             sz_err_o
);
  localparam int unsigned ACC_MAX = 3;

  logic [CNT_W-1:0] acc_bytes;

  always_comb begin
    acc_bytes = '0;
    for (int i = 0; i <= ACC_MAX; i++) begin
      if (acc_size_i == 2'(i)) acc_bytes[i] = 1'b1;
    end
  end

  always_comb begin
    unique case (xfer_mode_e'(mode_i))
      MODE_BLK: unit_o = blk_size_i;
      MODE_CLU: unit_o = clu_size_i;
      default:  unit_o = acc_bytes;
    endcase
  end

  assign sz_err_o = req_i && chan_en_i && (tcnt_i < unit_o);
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] dec_by_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_zero_o
);
  logic [CNT_W-1:0] rem;

  assign rem        = cnt_o - dec_by_i;
  assign hit_zero_o = dec_i && (rem == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (ld_i)  cnt_o <= ld_val_i;
    else if (dec_i) cnt_o <= rem;
  end
endmodule

// File: rtl/dma_run_track.sv
module dma_run_track #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             step_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] size_o,
  output logic [CNT_W-1:0] left_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] size_m1;

  assign zero_o  = (left_o == '0);
  assign size_m1 = (size_o == '0) ? '0 : size_o - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o <= '0;
      left_o <= '0;
    end else if (ld_i) begin
      size_o <= ld_val_i;
      left_o <= ld_val_i;
    end else if (reload_i) begin
      left_o <= size_o;
    end else if (step_i) begin
      left_o <= zero_o ? size_m1 : left_o - 1'b1;
    end
  end

  p_run_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !ld_i) |=> (left_o == size_o));
endmodule

// File: rtl/dma_flag_regs.sv
module dma_flag_regs
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              end_set_i,
  input  logic              spec_set_i,
  input  logic              halt_i,
  output logic              chan_en_o,
  output logic              end_flag_o,
  output logic              spec_flag_o,
  output logic [N_IE-1:0]   ie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_en_o   <= 1'b0;
      end_flag_o  <= 1'b0;
      spec_flag_o <= 1'b0;
      ie_o        <= '0;
    end else begin
      if (halt_i)    chan_en_o <= 1'b0;
      else if (wr_i) chan_en_o <= wdata_i[CB_EN];

      // hw set beats sw clear; enabling the channel drops the end flag
      if (end_set_i) end_flag_o <= 1'b1;
      else if (wr_i) end_flag_o <= end_flag_o && wdata_i[CB_ENDF] && !wdata_i[CB_EN];

      if (spec_set_i) spec_flag_o <= 1'b1;
      else if (wr_i)  spec_flag_o <= spec_flag_o && wdata_i[CB_SPF];

      if (wr_i) ie_o <= wdata_i[CB_IE +: N_IE];
    end
  end

  p_en_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(end_flag_o) || $rose(spec_flag_o)) |-> !chan_en_o);

  p_spec_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[CB_SPF] && !spec_set_i) |=> !spec_flag_o);
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
  import dma_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             req_i,
  input  logic [1:0]       xfer_mode_i,
  input  logic [1:0]       acc_size_i,
  input  logic [CNT_W-1:0] blk_size_i,
  input  logic [CNT_W-1:0] clu_size_i,
  input  logic             src_ovf_i,
  input  logic             dst_ovf_i,
  output logic             xfer_go_o,
  output logic             sz_err_o,
  output logic             irq_o
);
  logic             chan_en, end_flag, spec_flag;
  logic [N_IE-1:0]  ie;
  logic [CNT_W-1:0] tcnt, unit, rsz, run_left;
  logic             run_zero, cnt_zero_hit;
  logic             wr_ctrl, wr_tcnt, wr_rsz;
  logic             rpt_mode, rpt_evt, rpt_stop;
  logic [N_IE-1:0]  cause;
  logic             spec_set, end_set, halt;

  assign wr_ctrl  = reg_wr_i && (reg_addr_e'(reg_addr_i) == RA_CTRL);
  assign wr_tcnt  = reg_wr_i && (reg_addr_e'(reg_addr_i) == RA_TCNT);
  assign wr_rsz   = reg_wr_i && (reg_addr_e'(reg_addr_i) == RA_RSZ);
  assign rpt_mode = (xfer_mode_e'(xfer_mode_i) == MODE_RPT);

  dma_req_size #(.CNT_W(CNT_W)) u_size (
    .mode_i     (xfer_mode_i),
    .acc_size_i (acc_size_i),
    .blk_size_i (blk_size_i),
    .clu_size_i (clu_size_i),
    .tcnt_i     (tcnt),
    .req_i      (req_i),
    .chan_en_i  (chan_en),
    .unit_o     (unit),
    .sz_err_o   (sz_err_o)
  );

  assign rpt_evt   = req_i && chan_en && rpt_mode && run_zero && !sz_err_o;
  assign rpt_stop  = rpt_evt && ie[IE_RPT];
  assign xfer_go_o = req_i && chan_en && !sz_err_o && !rpt_stop;

  dma_xfer_cnt #(.CNT_W(CNT_W)) u_tcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (wr_tcnt),
    .ld_val_i   (reg_wdata_i),
    .dec_i      (xfer_go_o),
    .dec_by_i   (unit),
    .cnt_o      (tcnt),
    .hit_zero_o (cnt_zero_hit)
  );

  dma_run_track #(.CNT_W(CNT_W)) u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (wr_rsz),
    .ld_val_i (reg_wdata_i),
    .step_i   (xfer_go_o && rpt_mode),
    .reload_i (rpt_stop),
    .size_o   (rsz),
    .left_o   (run_left),
    .zero_o   (run_zero)
  );

  // raw causes indexed like the enable vector
  always_comb begin
    cause         = '0;
    cause[IE_END] = cnt_zero_hit;
    cause[IE_SZ]  = sz_err_o;
    cause[IE_RPT] = rpt_evt;
    cause[IE_SRC] = src_ovf_i;
    cause[IE_DST] = dst_ovf_i;
  end

  assign spec_set = |(cause[N_IE-1:IE_SZ] & ie[N_IE-1:IE_SZ]);
  assign end_set  = cause[IE_END] && ie[IE_END] && !spec_set;
  assign halt     = spec_set || end_set || sz_err_o;

  dma_flag_regs u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_ctrl),
    .wdata_i     (reg_wdata_i[CTRL_W-1:0]),
    .end_set_i   (end_set),
    .spec_set_i  (spec_set),
    .halt_i      (halt),
    .chan_en_o   (chan_en),
    .end_flag_o  (end_flag),
    .spec_flag_o (spec_flag),
    .ie_o        (ie)
  );

  assign irq_o = end_flag || spec_flag;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_addr_i))
      RA_CTRL: reg_rdata_o[CTRL_W-1:0] = {ie, spec_flag, end_flag, chan_en};
      RA_TCNT: reg_rdata_o = tcnt;
      RA_RSZ:  reg_rdata_o = rsz;
      default: reg_rdata_o = run_left;
    endcase
  end

  p_cnt_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sz_err_o && !wr_tcnt) |=> $stable(tcnt));

  p_end_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_flag) |-> $past(xfer_go_o && ie[IE_END]));

  p_go_unit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_go_o && !wr_tcnt) |=> (tcnt == $past(tcnt - unit)));
endmodule

// File: tb/dma_chan_irq_test.sv
`timescale 1ns/1ps
module dma_chan_irq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  acc = '0;
  logic [15:0] blk = '0;
  logic [15:0] clu = '0;
  logic        src = 1'b0;
  logic        dst = 1'b0;
  logic        go, szerr, irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_chan_irq uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_i(req),
    .xfer_mode_i(mode), .acc_size_i(acc), .blk_size_i(blk), .clu_size_i(clu),
    .src_ovf_i(src), .dst_ovf_i(dst), .xfer_go_o(go), .sz_err_o(szerr),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int m_en, m_endf, m_spf, m_cnt, m_rsz, m_run;
  int m_ie[5];

  always @(negedge clk) begin
    if (!rst_ni) begin
      m_en = 0; m_endf = 0; m_spf = 0; m_cnt = 0; m_rsz = 0; m_run = 0;
      foreach (m_ie[k]) m_ie[k] = 0;
    end else begin
      int unit, e_sz, e_rpt, e_go, e_rd, spec, endhit;
      unit = (mode == 1) ? int'(blk) : (mode == 2) ? int'(clu) : (1 << acc);
      e_sz  = (req && m_en && m_cnt < unit) ? 1 : 0;
      e_rpt = (req && m_en && mode == 3 && m_run == 0 && !e_sz) ? 1 : 0;
      e_go  = (req && m_en && !e_sz && !(e_rpt && m_ie[2])) ? 1 : 0;
      case (reg_addr)
        0: e_rd = m_en | (m_endf << 1) | (m_spf << 2) | (m_ie[0] << 3) | (m_ie[1] << 4)
                | (m_ie[2] << 5) | (m_ie[3] << 6) | (m_ie[4] << 7);
        1: e_rd = m_cnt;
        2: e_rd = m_rsz;
        default: e_rd = m_run;
      endcase
      chk("R2 go", go, e_go);
      chk("R3 size error", szerr, e_sz);
      chk("R10 irq", irq, (m_endf || m_spf) ? 1 : 0);
      chk("R9 readback", reg_rdata, e_rd);
      // next state
      spec = ((e_sz && m_ie[1]) || (e_rpt && m_ie[2]) || (src && m_ie[3]) || (dst && m_ie[4])) ? 1 : 0;
      endhit = (e_go && (m_cnt - unit) == 0 && m_ie[0] && !spec) ? 1 : 0;
      if (e_go && mode == 3)
        m_run = (m_run == 0) ? ((m_rsz == 0) ? 0 : m_rsz - 1) : m_run - 1;
      if (e_rpt && m_ie[2]) m_run = m_rsz;
      if (e_go) m_cnt = m_cnt - unit;
      if (reg_wr) begin
        case (reg_addr)
          0: begin
            m_endf = (m_endf && reg_wdata[1] && !reg_wdata[0]) ? 1 : 0;
            m_spf  = (m_spf && reg_wdata[2]) ? 1 : 0;
            m_en   = reg_wdata[0];
            for (int k = 0; k < 5; k++) m_ie[k] = reg_wdata[3+k];
          end
          1: m_cnt = reg_wdata;
          2: begin m_rsz = reg_wdata; m_run = reg_wdata; end
          default: ;
        endcase
      end
      if (spec) m_spf = 1;
      if (endhit) m_endf = 1;
      if (spec || endhit || e_sz) m_en = 0;
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input bit r, input bit s, input bit d);
    @(posedge clk); #1;
    req = r; src = s; dst = d;
    @(posedge clk); #1;
    req = 1'b0; src = 1'b0; dst = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    reg_addr = 2'(a);
    @(negedge clk); #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    rd(0, 0, "R1 ctrl"); rd(1, 0, "R1 tcnt"); rd(2, 0, "R1 rsz"); rd(3, 0, "R1 run");
    chk("R1 irq", irq, 0);

    // R2 R4 R8 R10: normal mode, 2-byte access, 8 bytes
    wr(0, 'h09); wr(1, 8); mode = 0; acc = 1;
    for (int i = 0; i < 4; i++) pulse(1, 0, 0);
    rd(1, 0, "R2 count");
    rd(0, 'h0A, "R4 R8 end flag, enable off");
    chk("R10 irq high", irq, 1);

    // R9 flag writes
    wr(0, 'h0A); rd(0, 'h0A, "R9 write 1 keeps flag");
    wr(0, 'h08); rd(0, 'h08, "R9 write 0 clears");
    chk("R10 irq low", irq, 0);
    wr(1, 2); wr(0, 'h09); pulse(1, 0, 0);
    rd(0, 'h0A, "R4 set again");
    wr(1, 4); wr(0, 'h0B); rd(0, 'h09, "R9 enable clears end flag");

    // R3 block size error
    mode = 1; blk = 6; wr(0, 'h19);
    @(posedge clk); #1 req = 1'b1;
    @(negedge clk);
    chk("R3 sz_err", szerr, 1); chk("R3 no go", go, 0);
    @(posedge clk); #1 req = 1'b0;
    rd(1, 4, "R3 count unchanged");
    rd(0, 'h1C, "R3 special flag");

    // R3 cluster mode
    wr(1, 9); wr(0, 'h19); mode = 2; clu = 3;
    for (int i = 0; i < 3; i++) pulse(1, 0, 0);
    rd(1, 0, "R3 cluster count");
    rd(0, 'h1A, "R3 cluster end");

    // R11 disabled sources
    wr(1, 1); wr(0, 'h01); mode = 1; blk = 6;
    pulse(1, 0, 0);
    rd(0, 'h00, "R11 size error unflagged");
    pulse(0, 0, 1);
    rd(0, 'h00, "R11 dst disabled");
    chk("R11 irq", irq, 0);

    // R5 overflow enabled
    wr(0, 'h40); pulse(0, 1, 0);
    rd(0, 'h44, "R5 src overflow");

    // R6 coincidence
    wr(1, 2); wr(0, 'h49); mode = 0; acc = 1;
    pulse(1, 1, 0);
    rd(0, 'h4C, "R6 special only");
    rd(1, 0, "R6 count");

    // R7 repeat with stop
    wr(0, 'h21); wr(1, 100); wr(2, 2); mode = 3; acc = 0;
    pulse(1, 0, 0); pulse(1, 0, 0);
    rd(3, 0, "R7 run done");
    @(posedge clk); #1 req = 1'b1;
    @(negedge clk); chk("R7 stop blocks", go, 0);
    @(posedge clk); #1 req = 1'b0;
    rd(0, 'h24, "R7 special flag");
    rd(3, 2, "R7 reload");
    rd(1, 98, "R7 count");
    // R7 repeat without stop
    wr(0, 'h01);
    for (int i = 0; i < 3; i++) pulse(1, 0, 0);
    rd(3, 1, "R7 run restart");
    rd(1, 95, "R7 count through");
    rd(0, 'h01, "R7 no flag");

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      req = ($urandom_range(0, 1) == 1);
      src = ($urandom_range(0, 19) == 0);
      dst = ($urandom_range(0, 19) == 0);
      reg_addr = 2'($urandom_range(0, 3));
      reg_wr = ($urandom_range(0, 7) == 0);
      if (reg_addr == 0) reg_wdata = 16'($urandom_range(0, 255) | 1);
      else reg_wdata = 16'($urandom_range(0, 40));
      if ($urandom_range(0, 31) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) acc = 2'($urandom_range(0, 3));
      blk = 16'($urandom_range(0, 8));
      clu = 16'($urandom_range(0, 8));
    end
    @(posedge clk); #1;
    req = 0; src = 0; dst = 0; reg_wr = 0;
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule